// File: doc/BRIEF.md
# Cache Region Policy Controller

This block holds the caching policy for a 64 MB physical address space split into thirty-two 2 MB regions. It turns each processor bus access into three cache control decisions:
- whether a read may be allocated into the cache;
- whether a write may refresh a line that is already cached;
- whether a write must throw away the whole cache.

The tag and data arrays, and the bus protocol around them, belong to other blocks. This block only produces the per-access decisions and a flush pulse.

Policy is held in three 32-bit region bitmaps (allocate-on-read, write-through-update, invalidate-on-write) and one cache enable bit. All four are programmed through a single register port. Each update is a masked read-modify-write: the stored value is ANDed with the mask, then XORed with the data. The resulting value comes back on the result output in the same cycle. This lets software set a register (mask 0), read it (data 0, mask all ones), or toggle bits without a separate read.

The enable bit is kept as a two-state machine with the states CACHE_OFF and CACHE_ON. It has these transitions:
- TURN_ON: a control write whose result bit 0 is 1, taken from CACHE_OFF.
- TURN_OFF: a control write whose result bit 0 is 0, taken from CACHE_ON.
- STAY: every other cycle.

A separate flush command, and any write that lands in an invalidate-on-write region, each produce a one-cycle flush pulse on the following cycle. This happens whether or not the cache is enabled.

Top module: `cache_policy_ctrl`

## Requirements
- R1: After reset the cache is disabled, the three bitmaps hold their reset parameters (defaults: allocate 0x0000FFFF, update 0x0000FFFF, invalidate 0x80000000), and flush_o is low.
- R2: With reg_stb high, reg_result equals (old AND reg_mask) XOR reg_wdata for the register chosen by reg_sel (0 = control, 1 = allocate, 2 = update, 3 = invalidate) in the same cycle; from the next cycle that value is stored.
- R3: Writing reg_wdata = 0 with reg_mask = all ones returns the current value and leaves it unchanged; writing reg_mask = 0 loads reg_wdata directly.
- R4: For the control register only bit 0 counts: the result is zero in bits 31:1, bit 0 of the result becomes the enable state, and enabling or disabling takes effect from the next cycle.
- R5: The region of an access is acc_addr[25:21]; bitmap bit k covers addresses k*0x200000 to k*0x200000+0x1FFFFF.
- R6: alloc_o is high in the same cycle as a valid read whose region bit in the allocate bitmap is set while the cache is enabled, and low otherwise (including for all writes).
- R7: update_o is high in the same cycle as a valid write whose region bit in the update bitmap is set while the cache is enabled, and low otherwise (including for all reads).
- R8: A valid write to a region whose invalidate bitmap bit is set makes flush_o high for exactly the next cycle, even while the cache is disabled; reads to that region and writes elsewhere do not.
- R9: flush_cmd high for one cycle makes flush_o high for exactly the next cycle, even while the cache is disabled.
- R10: While the cache is disabled, alloc_o and update_o stay low whatever the bitmaps hold.
- R11: An access in the same cycle as a register update is decided on the value before the update.
- R12: With reg_stb low, no register changes, whatever reg_sel, reg_wdata and reg_mask carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_stb | input | 1 | Register update strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 allocate, 2 update, 3 invalidate |
| reg_wdata | input | 32 | XOR data of the update |
| reg_mask | input | 32 | AND mask of the update |
| reg_result | output | 32 | New value of the selected register, valid with reg_stb |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| acc_addr | input | 26 | Byte address of the access |
| flush_cmd | input | 1 | Flush-all command |
| alloc_o | output | 1 | Read may be allocated |
| update_o | output | 1 | Write may update a cached line |
| flush_o | output | 1 | One-cycle invalidate-all pulse |

## Verification
A register update and a bus access can fall in the same cycle. The bench provokes this by setting the allocate bit of region 0 through the register port while a read to region 0 is on the bus. It expects alloc_o low in that cycle, because the old value is used. It expects alloc_o high in the following cycle with the same read still applied. A disruptive write also collides with a disabled cache: there the flush pulse must appear while alloc_o and update_o stay low.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL       = 2'd0,
        SEL_ALLOCATE   = 2'd1,
        SEL_UPDATE     = 2'd2,
        SEL_INVALIDATE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CACHE_OFF = 1'b0,
        CACHE_ON  = 1'b1
    } en_state_e;

    localparam int unsigned POLICY_COUNT = 3;

endpackage

// File: rtl/cpc_enable_fsm.sv
module cpc_enable_fsm
    import cpc_pkg::*;
#(
    parameter logic EN_RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_data0,
    input  logic ctl_mask0,
    output logic en_o,
    output logic ctl_result_o
);

    en_state_e state_q;
    en_state_e state_d;
    logic      ctl_next;

    // Masked update of the single meaningful bit
    always_comb begin
        ctl_next = ((state_q == CACHE_ON) & ctl_mask0) ^ ctl_data0;
        state_d  = state_q;
        if (ctl_wr) begin
            unique case (state_q)
                CACHE_OFF: if (ctl_next)  state_d = CACHE_ON;   // TURN_ON
                CACHE_ON:  if (!ctl_next) state_d = CACHE_OFF;  // TURN_OFF
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= en_state_e'(EN_RST);
        else        state_q <= state_d;
    end

    always_comb begin
        en_o         = (state_q == CACHE_ON);
        ctl_result_o = ctl_next;
    end

endmodule

// File: rtl/cpc_policy_regs.sv
module cpc_policy_regs
    import cpc_pkg::*;
#(
    parameter int unsigned        MASK_W = 32,
    parameter logic [MASK_W-1:0]  RST_ALLOC = '0,
    parameter logic [MASK_W-1:0]  RST_UPD   = '0,
    parameter logic [MASK_W-1:0]  RST_INV   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [1:0]        sel,
    input  logic [MASK_W-1:0] wdata,
    input  logic [MASK_W-1:0] wmask,
    output logic [MASK_W-1:0] alloc_map_o,
    output logic [MASK_W-1:0] upd_map_o,
    output logic [MASK_W-1:0] inv_map_o,
    output logic [MASK_W-1:0] result_o
);

    for (genvar g = 0; g < POLICY_COUNT; g++) begin : gen_pol
        localparam logic [MASK_W-1:0] RST_V =
            (g == 0) ? RST_ALLOC : (g == 1) ? RST_UPD : RST_INV;
        localparam logic [1:0] MY_SEL = 2'(g + 1);

        logic [MASK_W-1:0] q;
        logic [MASK_W-1:0] nxt;
        logic              hit;

        always_comb begin
            nxt = (q & wmask) ^ wdata;
            hit = stb && (sel == MY_SEL);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= RST_V;
            else if (hit) q <= nxt;
        end
    end

    assign alloc_map_o = gen_pol[0].q;
    assign upd_map_o   = gen_pol[1].q;
    assign inv_map_o   = gen_pol[2].q;

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_ALLOCATE:   result_o = gen_pol[0].nxt;
            SEL_UPDATE:     result_o = gen_pol[1].nxt;
            SEL_INVALIDATE: result_o = gen_pol[2].nxt;
            default:        result_o = '0;
        endcase
    end

endmodule

// File: rtl/cpc_access_decide.sv
module cpc_access_decide #(
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned MASK_W = 32
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              en,
    input  logic [MASK_W-1:0] alloc_map,
    input  logic [MASK_W-1:0] upd_map,
    input  logic [MASK_W-1:0] inv_map,
    output logic              alloc_o,
    output logic              update_o,
    output logic              inv_req_o
);

    logic [IDX_W-1:0] idx;
    logic             rd;
    logic             wr;

    always_comb begin
        idx       = acc_addr[ADDR_W-1 -: IDX_W];
        rd        = acc_valid && !acc_write;
        wr        = acc_valid && acc_write;
        alloc_o   = rd && en && alloc_map[idx];
        update_o  = wr && en && upd_map[idx];
        inv_req_o = wr && inv_map[idx];
    end

endmodule

// File: rtl/cache_policy_ctrl.sv
module cache_policy_ctrl
    import cpc_pkg::*;
#(
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned IDX_W  = 5,
    parameter logic [(1<<IDX_W)-1:0] RST_ALLOC = 32'h0000_FFFF,
    parameter logic [(1<<IDX_W)-1:0] RST_UPD   = 32'h0000_FFFF,
    parameter logic [(1<<IDX_W)-1:0] RST_INV   = 32'h8000_0000,
    parameter logic EN_RST = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_stb,
    input  logic [1:0]              reg_sel,
    input  logic [(1<<IDX_W)-1:0]   reg_wdata,
    input  logic [(1<<IDX_W)-1:0]   reg_mask,
    output logic [(1<<IDX_W)-1:0]   reg_result,
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic                    flush_cmd,
    output logic                    alloc_o,
    output logic                    update_o,
    output logic                    flush_o
);

    localparam int unsigned MASK_W = 1 << IDX_W;

    logic              cache_en;
    logic              ctl_res;
    logic [MASK_W-1:0] map_alloc;
    logic [MASK_W-1:0] map_upd;
    logic [MASK_W-1:0] map_inv;
    logic [MASK_W-1:0] pol_res;
    logic              inv_req;
    logic              flush_q;

    cpc_enable_fsm #(.EN_RST(EN_RST)) u_en (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (reg_stb && (reg_sel == SEL_CTRL)),
        .ctl_data0    (reg_wdata[0]),
        .ctl_mask0    (reg_mask[0]),
        .en_o         (cache_en),
        .ctl_result_o (ctl_res)
    );

    cpc_policy_regs #(
        .MASK_W    (MASK_W),
        .RST_ALLOC (RST_ALLOC),
        .RST_UPD   (RST_UPD),
        .RST_INV   (RST_INV)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb         (reg_stb),
        .sel         (reg_sel),
        .wdata       (reg_wdata),
        .wmask       (reg_mask),
        .alloc_map_o (map_alloc),
        .upd_map_o   (map_upd),
        .inv_map_o   (map_inv),
        .result_o    (pol_res)
    );

    cpc_access_decide #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .MASK_W (MASK_W)
    ) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .en        (cache_en),
        .alloc_map (map_alloc),
        .upd_map   (map_upd),
        .inv_map   (map_inv),
        .alloc_o   (alloc_o),
        .update_o  (update_o),
        .inv_req_o (inv_req)
    );

    always_comb begin
        if (reg_sel == SEL_CTRL) reg_result = {{(MASK_W-1){1'b0}}, ctl_res};
        else                     reg_result = pol_res;
    end

    // One flush cycle after each requesting cycle, independent of enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= inv_req || flush_cmd;
    end

    assign flush_o = flush_q;

endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
    parameter int unsigned MASK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_stb,
    input logic [1:0]        reg_sel,
    input logic [MASK_W-1:0] reg_wdata,
    input logic [MASK_W-1:0] reg_mask,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              flush_cmd,
    input logic              alloc_o,
    input logic              update_o,
    input logic              flush_o,
    input logic              en,
    input logic [MASK_W-1:0] map_alloc,
    input logic [MASK_W-1:0] map_upd,
    input logic [MASK_W-1:0] map_inv
);

    assert_off_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!alloc_o && !update_o));

    assert_alloc_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_o |-> (acc_valid && !acc_write));

    assert_update_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (acc_valid && acc_write));

    assert_flush_cmd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_cmd |=> flush_o);

    assert_flush_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(flush_cmd || (acc_valid && acc_write)));

    assert_idle_keeps_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_stb |=> ($stable(map_alloc) && $stable(map_upd) && $stable(map_inv) && $stable(en)));

    assert_rmw_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_stb && reg_sel == 2'd1) |=> (map_alloc == $past((map_alloc & reg_mask) ^ reg_wdata)));

    assert_ctl_read_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_stb && reg_sel == 2'd0 && reg_mask[0] && !reg_wdata[0]) |=> $stable(en));

endmodule

bind cache_policy_ctrl cpc_checker #(.MASK_W(MASK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_stb   (reg_stb),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_mask  (reg_mask),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .flush_cmd (flush_cmd),
    .alloc_o   (alloc_o),
    .update_o  (update_o),
    .flush_o   (flush_o),
    .en        (cache_en),
    .map_alloc (map_alloc),
    .map_upd   (map_upd),
    .map_inv   (map_inv)
);

// File: tb/cache_policy_ctrl_bench.sv
module cache_policy_ctrl_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_stb = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_mask = '0;
    logic [31:0] reg_result;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [25:0] acc_addr = '0;
    logic        flush_cmd = 1'b0;
    logic        alloc_o;
    logic        update_o;
    logic        flush_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_policy_ctrl u_cache_policy_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_stb(reg_stb), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_mask(reg_mask), .reg_result(reg_result),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .flush_cmd(flush_cmd), .alloc_o(alloc_o), .update_o(update_o),
        .flush_o(flush_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One register operation: drive at a falling edge, capture result, commit at rising edge
    task automatic reg_op(input logic [1:0] sel, input logic [31:0] d, input logic [31:0] m,
                          output logic [31:0] res);
        @(negedge clk);
        reg_stb = 1'b1; reg_sel = sel; reg_wdata = d; reg_mask = m;
        #1 res = reg_result;
        @(negedge clk);
        reg_stb = 1'b0; reg_wdata = '0; reg_mask = '0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [31:0] res);
        reg_op(sel, 32'h0, 32'hFFFF_FFFF, res);
    endtask

    // One access; a, u sampled in the access cycle, f1 the next cycle, f2 the one after
    task automatic access(input logic wr, input logic [25:0] addr, input logic fc,
                          output logic a, output logic u, output logic f1, output logic f2);
        @(negedge clk);
        acc_valid = !fc; acc_write = wr; acc_addr = addr; flush_cmd = fc;
        #1 a = alloc_o; u = update_o;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; flush_cmd = 1'b0;
        #1 f1 = flush_o;
        @(negedge clk);
        #1 f2 = flush_o;
    endtask

    task automatic t_reset;
        logic [31:0] r;
        logic a, u, f1, f2;
        chk("R1 flush after reset", 32'(flush_o), 32'h0);
        reg_read(2'd0, r); chk("R1 enable reset", r, 32'h0);
        reg_read(2'd1, r); chk("R1 allocate reset", r, 32'h0000_FFFF);
        reg_read(2'd2, r); chk("R1 update reset", r, 32'h0000_FFFF);
        reg_read(2'd3, r); chk("R1 invalidate reset", r, 32'h8000_0000);
        access(1'b0, 26'h000_0000, 1'b0, a, u, f1, f2);
        chk("R10 read while disabled at reset", 32'(a), 32'h0);
    endtask

    task automatic t_rmw;
        logic [31:0] r;
        reg_op(2'd1, 32'hA5A5_1234, 32'h0, r);
        chk("R3 mask zero loads data", r, 32'hA5A5_1234);
        reg_read(2'd1, r);
        chk("R2 stored value", r, 32'hA5A5_1234);
        reg_op(2'd1, 32'h0F0F_0F0F, 32'hFF00_FF00, r);
        chk("R2 and-then-xor result", r, (32'hA5A5_1234 & 32'hFF00_FF00) ^ 32'h0F0F_0F0F);
        reg_read(2'd1, r);
        chk("R3 read leaves unchanged", r, (32'hA5A5_1234 & 32'hFF00_FF00) ^ 32'h0F0F_0F0F);
        reg_op(2'd2, 32'h0000_00FF, 32'hFFFF_FFFF, r);
        chk("R2 toggle update low byte", r, 32'h0000_FF00);
    endtask

    task automatic t_ctl;
        logic [31:0] r;
        reg_op(2'd0, 32'hFFFF_FFFE, 32'h0, r);
        chk("R4 upper bits ignored", r, 32'h0);
        reg_op(2'd0, 32'h0000_0001, 32'h0, r);
        chk("R4 enable result", r, 32'h1);
        reg_read(2'd0, r);
        chk("R4 enable stored", r, 32'h1);
        reg_op(2'd0, 32'h1, 32'hFFFF_FFFF, r);
        chk("R4 toggle off", r, 32'h0);
        reg_read(2'd0, r);
        chk("R4 disabled stored", r, 32'h0);
        reg_op(2'd0, 32'h1, 32'h0, r);
    endtask

    task automatic t_alloc;
        logic [31:0] r;
        logic a, u, f1, f2;
        reg_op(2'd1, 32'h0000_0005, 32'h0, r);
        access(1'b0, 26'h000_0000, 1'b0, a, u, f1, f2); chk("R6 read region 0", 32'(a), 32'h1);
        access(1'b0, 26'h01F_FFFF, 1'b0, a, u, f1, f2); chk("R5 top of region 0", 32'(a), 32'h1);
        access(1'b0, 26'h020_0000, 1'b0, a, u, f1, f2); chk("R5 base of region 1", 32'(a), 32'h0);
        access(1'b0, 26'h040_0000, 1'b0, a, u, f1, f2); chk("R5 region 2", 32'(a), 32'h1);
        access(1'b0, 26'h3FF_FFFF, 1'b0, a, u, f1, f2); chk("R5 region 31", 32'(a), 32'h0);
        access(1'b1, 26'h000_0000, 1'b0, a, u, f1, f2); chk("R6 write never allocates", 32'(a), 32'h0);
    endtask

    task automatic t_update;
        logic [31:0] r;
        logic a, u, f1, f2;
        reg_op(2'd2, 32'h8000_0001, 32'h0, r);
        access(1'b1, 26'h010_0000, 1'b0, a, u, f1, f2); chk("R7 write region 0", 32'(u), 32'h1);
        access(1'b1, 26'h3E0_0000, 1'b0, a, u, f1, f2); chk("R7 write region 31", 32'(u), 32'h1);
        access(1'b1, 26'h0A0_0000, 1'b0, a, u, f1, f2); chk("R7 write region 5", 32'(u), 32'h0);
        access(1'b0, 26'h000_0000, 1'b0, a, u, f1, f2); chk("R7 read never updates", 32'(u), 32'h0);
    endtask

    task automatic t_disrupt;
        logic [31:0] r;
        logic a, u, f1, f2;
        reg_op(2'd3, 32'h0000_0008, 32'h0, r);
        access(1'b1, 26'h060_0000, 1'b0, a, u, f1, f2);
        chk("R8 flush next cycle", 32'(f1), 32'h1);
        chk("R8 flush one cycle", 32'(f2), 32'h0);
        access(1'b0, 26'h060_0000, 1'b0, a, u, f1, f2); chk("R8 read no flush", 32'(f1), 32'h0);
        access(1'b1, 26'h080_0000, 1'b0, a, u, f1, f2); chk("R8 other region no flush", 32'(f1), 32'h0);
        reg_op(2'd2, 32'h0000_0008, 32'h0, r);
        reg_op(2'd1, 32'h0000_0008, 32'h0, r);
        reg_op(2'd0, 32'h0, 32'h0, r);
        access(1'b1, 26'h060_0000, 1'b0, a, u, f1, f2);
        chk("R8 flush while disabled", 32'(f1), 32'h1);
        chk("R10 update blocked while disabled", 32'(u), 32'h0);
        access(1'b0, 26'h060_0000, 1'b0, a, u, f1, f2);
        chk("R10 alloc blocked while disabled", 32'(a), 32'h0);
    endtask

    task automatic t_flush_cmd;
        logic a, u, f1, f2;
        access(1'b0, 26'h0, 1'b1, a, u, f1, f2);
        chk("R9 command flush next cycle", 32'(f1), 32'h1);
        chk("R9 command flush one cycle", 32'(f2), 32'h0);
    endtask

    task automatic t_same_cycle;
        logic [31:0] r;
        logic a;
        reg_op(2'd0, 32'h1, 32'h0, r);
        reg_op(2'd1, 32'h0, 32'h0, r);
        @(negedge clk);
        reg_stb = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h1; reg_mask = 32'hFFFF_FFFE;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 26'h000_4000;
        #1 a = alloc_o;
        chk("R11 access uses old value", 32'(a), 32'h0);
        @(negedge clk);
        reg_stb = 1'b0; reg_wdata = '0; reg_mask = '0;
        #1 a = alloc_o;
        chk("R11 new value next cycle", 32'(a), 32'h1);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_no_strobe;
        logic [31:0] r;
        @(negedge clk);
        reg_sel = 2'd3; reg_wdata = 32'hFFFF_FFFF; reg_mask = 32'h0;
        @(negedge clk);
        reg_sel = 2'd0; reg_wdata = 32'h0; reg_mask = 32'h0;
        @(negedge clk);
        reg_read(2'd3, r); chk("R12 invalidate kept", r, 32'h0000_0008);
        reg_read(2'd0, r); chk("R12 enable kept", r, 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset;
        t_rmw;
        t_ctl;
        t_alloc;
        t_update;
        t_disrupt;
        t_flush_cmd;
        t_same_cycle;
        t_no_strobe;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule